// File: doc/BRIEF.md
# Bus Cycle Arbiter Sequencer

This controller sits between a network controller, the host expansion bus and the on-board registers. In its idle state it looks at three request sources: a DMA hold request from the network controller, a network controller interrupt, and a host I/O access. It picks one of them and then runs the chosen board cycle. A 3-bit phase counter times each cycle from start to end. The current cycle is shown as a 4-bit code. Other blocks decode this code to drive buses and latches.

DMA work always starts with a synchronising request cycle. The request cycle waits for the expansion bus grant and then moves straight into a DMA read or DMA write. DMA cycles follow one another with no idle between them for as long as the hold request stays high. This covers single fetches and bursts of any length up to the controller's limit.

An accepted interrupt runs three linked cycles with no idle between them: a status read, a status DMA write into memory, and a status clear write. The host interrupt output is high during the clear write. Host cycles start only from idle and always return to idle.

Top module: `bus_cycle_sequencer`

## Requirements
- R1: While reset is low, and after its release until a request is seen, the cycle code is 0 (idle), the phase is 0, and hold_ack, bus_req, io_cycle, host_irq and host_ack are all low.
- R2: When the machine is in idle and several requests are pending, the next cycle is chosen in this order. A high hold_req gives the request cycle (code 1). Otherwise, ctl_irq with dma_en high gives the status read (code 4). Otherwise, host_req gives a host cycle. The chosen cycle starts at the next clock edge.
- R3: The host cycle code is set by host_kind and host_rw (host_rw=1 means read). host_kind 0 gives on-board read 7 or on-board write 8. host_kind 1 gives controller register read 9 or controller register write 10. host_kind 2 or 3 gives data-latch read 11 for a read, or on-board write 8 for a write. Codes 7, 8 and 11 last SHORT_LEN phases and raise io_cycle. Codes 9 and 10 last LONG_LEN phases. host_ack is high in the last phase. Every host cycle returns to idle, and a host request that arrives during another cycle waits for idle.
- R4: The request cycle (code 1) holds bus_req high and stays at phase 0 until bus_grant is sampled high. It then moves directly to DMA read (code 2) when dma_dir_wr is 0, or to DMA write (code 3) when dma_dir_wr is 1.
- R5: At the last phase of a DMA cycle (LONG_LEN phases), a high hold_req starts another DMA cycle directly, with the direction taken from dma_dir_wr. A low hold_req returns the machine to idle.
- R6: The interrupt chain runs status read (4), then status DMA write (5), then status clear (6), then idle, with no idle in between. host_irq is high exactly while the code is 6.
- R7: When dma_en is low, ctl_irq has no effect: no code 4, 5 or 6 appears, and host requests are served as if no interrupt were pending.
- R8: In codes 2, 3, 4, 6, 9 and 10, the phase holds at WAIT_PH while ctl_ready is low.
- R9: The status DMA write (code 5) holds at phase 0 until bus_grant is high.
- R10: hold_ack is high only in codes 2 and 3. bus_req is high only in codes 1, 2, 3 and 5.
- R11: Every new cycle starts at phase 0. The phase advances by one on each clock that is not a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req | input | 1 | DMA hold request from the network controller |
| dma_dir_wr | input | 1 | DMA direction: 1 writes memory, 0 reads memory |
| ctl_irq | input | 1 | Network controller interrupt, a level signal |
| dma_en | input | 1 | DMA-enable control bit; gates the interrupt chain |
| host_req | input | 1 | Host I/O access pending, held until host_ack |
| host_rw | input | 1 | Host access direction: 1 read, 0 write |
| host_kind | input | 2 | Host target: 0 on-board, 1 controller register, 2/3 data latch |
| bus_grant | input | 1 | Expansion bus grant |
| ctl_ready | input | 1 | Network controller data-phase ready |
| cyc_code | output | 4 | Current cycle type code |
| cyc_phase | output | 3 | Sub-cycle timing phase |
| hold_ack | output | 1 | Hold acknowledge to the network controller |
| bus_req | output | 1 | Expansion bus request |
| io_cycle | output | 1 | On-board non-controller I/O cycle active |
| host_irq | output | 1 | Interrupt to the host |
| host_ack | output | 1 | Last phase of a host cycle |

## Verification
The hardest condition to reach from the ports is a host request that arrives while a DMA burst is waiting. The burst is stalled on ready, and the request must wait until idle without breaking the burst. It is also hard to create all three requests at once, so that the order DMA, then interrupt chain, then host can be seen. The bench uses a reactive responder. The responder delays the grant and ready by set amounts, counts DMA cycle starts so it can drop hold_req after an exact word count, and raises the other requests in the same clock or in the middle of a cycle. The full sequence of cycle codes is then recorded and compared.

// File: rtl/bcs_pkg.sv
// Package: shared cycle-type encoding for the bus cycle sequencer.
// Assumes: 4-bit cycle codes; code values are decoded by neighbouring blocks.
package bcs_pkg;

    typedef enum logic [3:0] {
        CY_IDLE  = 4'd0,
        CY_DREQ  = 4'd1,
        CY_DMARD = 4'd2,
        CY_DMAWR = 4'd3,
        CY_STRD  = 4'd4,
        CY_STDMA = 4'd5,
        CY_STCLR = 4'd6,
        CY_IORD  = 4'd7,
        CY_IOWR  = 4'd8,
        CY_CTLRD = 4'd9,
        CY_CTLWR = 4'd10,
        CY_LATRD = 4'd11
    } cyc_t;

    // Host target selector values on host_kind
    localparam logic [1:0] HK_ONBOARD = 2'd0;
    localparam logic [1:0] HK_CTLREG  = 2'd1;

    // True for cycles issued by the host
    function automatic logic is_host(input cyc_t c);
        return (c == CY_IORD) || (c == CY_IOWR) || (c == CY_LATRD) ||
               (c == CY_CTLRD) || (c == CY_CTLWR);
    endfunction

    // True for short on-board cycles with no wait states
    function automatic logic is_short(input cyc_t c);
        return (c == CY_IORD) || (c == CY_IOWR) || (c == CY_LATRD);
    endfunction

    // True for cycles whose data phase waits on controller ready
    function automatic logic is_ready_class(input cyc_t c);
        return (c == CY_DMARD) || (c == CY_DMAWR) || (c == CY_STRD) ||
               (c == CY_STCLR) || (c == CY_CTLRD) || (c == CY_CTLWR);
    endfunction

endpackage

// File: rtl/bcs_arbiter.sv
// Module: idle-state request arbiter.
// Picks the cycle to start from idle: DMA hold, then the enabled
// interrupt, then the host. Returns CY_IDLE when nothing is pending.
// Assumes: inputs are stable around the sampling edge; purely combinational.
module bcs_arbiter
    import bcs_pkg::*;
(
    input  logic       hold_req,
    input  logic       irq_ok,
    input  logic       host_req,
    input  logic       host_rw,
    input  logic [1:0] host_kind,
    output cyc_t       start_cyc
);

    cyc_t host_cyc;

    // Map the host target and direction to a cycle type
    always_comb begin
        if (host_kind == HK_CTLREG)
            host_cyc = host_rw ? CY_CTLRD : CY_CTLWR;
        else if (host_kind == HK_ONBOARD)
            host_cyc = host_rw ? CY_IORD : CY_IOWR;
        else
            host_cyc = host_rw ? CY_LATRD : CY_IOWR;
    end

    // Fixed-priority choice among pending sources
    always_comb begin
        if (hold_req)
            start_cyc = CY_DREQ;
        else if (irq_ok)
            start_cyc = CY_STRD;
        else if (host_req)
            start_cyc = host_cyc;
        else
            start_cyc = CY_IDLE;
    end

endmodule

// File: rtl/bcs_timing.sv
// Module: per-cycle length and wait-state decoder.
// Gives whether the current phase is a wait state and whether it is the
// final phase of the cycle. Assumes LONG_LEN and SHORT_LEN fit in PW bits
// and WAIT_PH < LONG_LEN.
module bcs_timing
    import bcs_pkg::*;
#(
    parameter int PW        = 3,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6,
    parameter int WAIT_PH   = 2
) (
    input  cyc_t          cyc,
    input  logic [PW-1:0] phase,
    input  logic          bus_grant,
    input  logic          ctl_ready,
    output logic          stall,
    output logic          last_phase
);

    localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_LEN - 1);
    localparam logic [PW-1:0] LONG_LAST  = PW'(LONG_LEN - 1);
    localparam logic [PW-1:0] WAIT_AT    = PW'(WAIT_PH);

    // Wait-state decision for the current cycle and phase
    always_comb begin
        if (cyc == CY_DREQ)
            stall = !bus_grant;
        else if (cyc == CY_STDMA)
            stall = (phase == '0) && !bus_grant;
        else if (is_ready_class(cyc))
            stall = (phase == WAIT_AT) && !ctl_ready;
        else
            stall = 1'b0;
    end

    // Final-phase decode from the cycle length class
    always_comb begin
        if (cyc == CY_DREQ || cyc == CY_IDLE)
            last_phase = 1'b1;
        else if (is_short(cyc))
            last_phase = (phase == SHORT_LAST);
        else
            last_phase = (phase == LONG_LAST);
    end

endmodule

// File: rtl/bcs_phase_ctr.sv
// Module: sub-cycle phase counter.
// Restarts at zero at each cycle boundary and advances on unstalled clocks.
// Assumes restart has priority over step.
module bcs_phase_ctr #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [PW-1:0] phase
);

    // Phase register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (restart)
            phase <= '0;
        else if (step)
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/bus_cycle_sequencer.sv
// Module: bus cycle arbiter and sequencer (top).
// Picks a board cycle in idle and runs it phase by phase. DMA cycles
// chain while the hold request stays high. An accepted interrupt runs the
// status read / status DMA / status clear chain. Host cycles run from idle
// back to idle.
// Assumes: synchronous active-low reset; requests are levels held by
// their sources until served.
module bus_cycle_sequencer
    import bcs_pkg::*;
#(
    parameter int PW        = 3,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6,
    parameter int WAIT_PH   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_req,
    input  logic          dma_dir_wr,
    input  logic          ctl_irq,
    input  logic          dma_en,
    input  logic          host_req,
    input  logic          host_rw,
    input  logic [1:0]    host_kind,
    input  logic          bus_grant,
    input  logic          ctl_ready,
    output logic [3:0]    cyc_code,
    output logic [PW-1:0] cyc_phase,
    output logic          hold_ack,
    output logic          bus_req,
    output logic          io_cycle,
    output logic          host_irq,
    output logic          host_ack
);

    cyc_t cur_cyc;
    cyc_t start_cyc;
    cyc_t follow_cyc;
    cyc_t dma_cyc;
    logic stall;
    logic last_phase;
    logic cyc_end;

    bcs_arbiter u_arb (
        .hold_req  (hold_req),
        .irq_ok    (ctl_irq & dma_en),
        .host_req  (host_req),
        .host_rw   (host_rw),
        .host_kind (host_kind),
        .start_cyc (start_cyc)
    );

    bcs_timing #(
        .PW        (PW),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .WAIT_PH   (WAIT_PH)
    ) u_tim (
        .cyc        (cur_cyc),
        .phase      (cyc_phase),
        .bus_grant  (bus_grant),
        .ctl_ready  (ctl_ready),
        .stall      (stall),
        .last_phase (last_phase)
    );

    assign cyc_end = (cur_cyc != CY_IDLE) && !stall && last_phase;

    bcs_phase_ctr #(.PW(PW)) u_ph (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart ((cur_cyc == CY_IDLE) || cyc_end),
        .step    (!stall),
        .phase   (cyc_phase)
    );

    assign dma_cyc = dma_dir_wr ? CY_DMAWR : CY_DMARD;

    // Successor of a cycle that completes this clock
    always_comb begin
        case (cur_cyc)
            CY_DREQ:  follow_cyc = dma_cyc;
            CY_DMARD,
            CY_DMAWR: follow_cyc = hold_req ? dma_cyc : CY_IDLE;
            CY_STRD:  follow_cyc = CY_STDMA;
            CY_STDMA: follow_cyc = CY_STCLR;
            default:  follow_cyc = CY_IDLE;
        endcase
    end

    // Cycle-type state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_cyc <= CY_IDLE;
        else if (cur_cyc == CY_IDLE)
            cur_cyc <= start_cyc;
        else if (cyc_end)
            cur_cyc <= follow_cyc;
    end

    // Output decode from the current cycle
    always_comb begin
        cyc_code = cur_cyc;
        hold_ack = (cur_cyc == CY_DMARD) || (cur_cyc == CY_DMAWR);
        bus_req  = (cur_cyc == CY_DREQ) || hold_ack || (cur_cyc == CY_STDMA);
        io_cycle = is_short(cur_cyc);
        host_irq = (cur_cyc == CY_STCLR);
        host_ack = is_host(cur_cyc) && last_phase;
    end

endmodule

// File: rtl/bcs_checker.sv
// Module: protocol checker for bus_cycle_sequencer, attached by bind.
// Assumes: port names match the top module.
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int PW      = 3,
    parameter int WAIT_PH = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold_req,
    input logic          dma_en,
    input logic          ctl_ready,
    input logic          bus_grant,
    input logic [3:0]    cyc_code,
    input logic [PW-1:0] cyc_phase,
    input logic          hold_ack,
    input logic          host_irq
);

    logic c_host, c_idle, c_ready_cls;
    assign c_host      = (cyc_code >= 4'd7) && (cyc_code <= 4'd11);
    assign c_idle      = (cyc_code == 4'd0);
    assign c_ready_cls = (cyc_code == 4'd2) || (cyc_code == 4'd3) || (cyc_code == 4'd4) ||
                         (cyc_code == 4'd6) || (cyc_code == 4'd9) || (cyc_code == 4'd10);

    // R1: idle carries no acknowledge or interrupt
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        c_idle |-> (!hold_ack && !host_irq));

    // R3: host cycles are entered only from idle or themselves
    a_r3_host_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_host && !c_idle) |=> !c_host);

    // R4: a granted request cycle proceeds to a DMA data cycle
    a_r4_req_to_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_code == 4'd1 && bus_grant) |=> (cyc_code == 4'd2 || cyc_code == 4'd3));

    // R6: status chain order
    a_r6_chain_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_code == 4'd4) |=> (cyc_code == 4'd4 || cyc_code == 4'd5));
    a_r6_chain_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_code == 4'd5) |=> (cyc_code == 4'd5 || cyc_code == 4'd6));
    a_r6_chain_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_code == 4'd6) |=> (cyc_code == 4'd6 || cyc_code == 4'd0));

    // R7: disabled DMA keeps the interrupt chain from starting
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (c_idle && !dma_en && !hold_req) |=> (cyc_code != 4'd4));

    // R8: ready wait holds the phase and cycle
    a_r8_ready_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ready_cls && cyc_phase == PW'(WAIT_PH) && !ctl_ready) |=>
            ($stable(cyc_phase) && $stable(cyc_code)));

    // R10: hold acknowledge only in DMA data cycles
    a_r10_ack_only_dma: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (cyc_code == 4'd2 || cyc_code == 4'd3));

    // R11: a change of cycle starts at phase zero
    a_r11_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cyc_code) |-> (cyc_phase == '0));

endmodule

bind bus_cycle_sequencer bcs_checker #(.PW(PW), .WAIT_PH(WAIT_PH)) u_chk (.*);

// File: tb/sim_bus_cycle_sequencer.sv
module sim_bus_cycle_sequencer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 0, dma_dir_wr = 0, ctl_irq = 0, dma_en = 0;
    logic host_req = 0, host_rw = 0, bus_grant = 0, ctl_ready = 1;
    logic [1:0] host_kind = 0;
    logic [3:0] cyc_code;
    logic [2:0] cyc_phase;
    logic hold_ack, bus_req, io_cycle, host_irq, host_ack;

    always #2 clk = ~clk;   // 250 MHz

    bus_cycle_sequencer u0 (.*);

    int n_cmp = 0, n_bad = 0, ncyc = 0;
    int m_s = 0, m_ph = 0;
    int gcnt = 0, rcnt = 0, grant_dly = 0, rdy_dly = 0;
    int hold_target = 0, dma_seen = 0, gaps = 0, host_done = 0;
    int last_code = 0;
    int seq[$];
    int exp_q[$];

    function automatic int m_len(int s);
        if (s == 7 || s == 8 || s == 11) return 4;
        if (s == 0 || s == 1) return 1;
        return 6;
    endfunction

    function automatic bit m_rdycls(int s);
        return s == 2 || s == 3 || s == 4 || s == 6 || s == 9 || s == 10;
    endfunction

    function automatic bit m_stall(int s, int ph, bit g, bit r);
        if (s == 1) return !g;
        if (s == 5) return ph == 0 && !g;
        if (m_rdycls(s)) return ph == 2 && !r;
        return 0;
    endfunction

    function automatic int m_pick();
        if (hold_req) return 1;
        if (ctl_irq && dma_en) return 4;
        if (host_req) begin
            if (host_kind == 1) return host_rw ? 9 : 10;
            if (host_kind >= 2) return host_rw ? 11 : 8;
            return host_rw ? 7 : 8;
        end
        return 0;
    endfunction

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s = 0; m_ph = 0;
        end else if (m_s == 0) begin
            m_s = m_pick(); m_ph = 0;
        end else if (!m_stall(m_s, m_ph, bus_grant, ctl_ready)) begin
            if (m_ph == m_len(m_s) - 1) begin
                case (m_s)
                    1: m_s = dma_dir_wr ? 3 : 2;
                    2, 3: m_s = hold_req ? (dma_dir_wr ? 3 : 2) : 0;
                    4: m_s = 5;
                    5: m_s = 6;
                    default: m_s = 0;
                endcase
                m_ph = 0;
            end else m_ph = m_ph + 1;
        end
    end

    task automatic chk(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    function automatic string state_tag(int s);
        case (s)
            0: return "R2 idle";
            1: return "R4 request";
            2, 3: return "R5 dma";
            4, 6: return "R6 status";
            5: return "R9 status-dma";
            default: return "R3 host";
        endcase
    endfunction

    // One clock: compare on the falling edge, then respond
    task automatic tick();
        int eh;
        @(negedge clk);
        ncyc++;
        if (rst_n) begin
            chk(state_tag(m_s), int'(cyc_code), m_s);
            chk((m_rdycls(m_s) && m_ph == 2) ? "R8 phase" : "R11 phase", int'(cyc_phase), m_ph);
            chk("R10 hold_ack", int'(hold_ack), int'(m_s == 2 || m_s == 3));
            chk("R10 bus_req", int'(bus_req), int'(m_s == 1 || m_s == 2 || m_s == 3 || m_s == 5));
            chk("R3 io_cycle", int'(io_cycle), int'(m_s == 7 || m_s == 8 || m_s == 11));
            chk("R6 host_irq", int'(host_irq), int'(m_s == 6));
            eh = (m_s >= 7 && m_s <= 11 && m_ph == m_len(m_s) - 1) ? 1 : 0;
            chk("R3 host_ack", int'(host_ack), eh);
        end
        if (int'(cyc_code) != last_code) begin
            seq.push_back(int'(cyc_code));
            last_code = int'(cyc_code);
        end
        if (bus_req) gcnt++; else gcnt = 0;
        bus_grant = bus_req && (gcnt > grant_dly);
        if (cyc_phase == 3'd2) rcnt++; else rcnt = 0;
        ctl_ready = (cyc_phase != 3'd2) || (rcnt > rdy_dly);
        if (host_ack && host_req) begin host_req = 0; host_done++; end
        if (cyc_code == 4'd6) ctl_irq = 0;
        if (hold_req && (cyc_code == 4'd2 || cyc_code == 4'd3) && cyc_phase == 3'd0) begin
            dma_seen++;
            if (dma_seen >= hold_target) hold_req = 0;
        end
        if (dma_seen > 0 && dma_seen < hold_target && cyc_code == 4'd0) gaps++;
        if (ncyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R0 actual=%0d expected<150000", ncyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while ((hold_req || host_req || (ctl_irq && dma_en) || cyc_code != 0) && n < 400) begin
            tick(); n++;
        end
        if (n >= 400) begin
            n_bad++;
            $display("FAIL %s watchdog actual=%0d expected<400", tag, n);
        end
        tick(); tick();
    endtask

    task automatic check_seq(string tag);
        n_cmp++;
        if (seq != exp_q) begin
            n_bad++;
            $display("FAIL %s actual=%p expected=%p", tag, seq, exp_q);
        end
        seq.delete();
    endtask

    task automatic host_op(int kind, bit rw, int code, string tag);
        host_kind = 2'(kind); host_rw = rw; host_req = 1;
        wait_done(tag);
        exp_q = '{code, 0};
        check_seq(tag);
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 code", int'(cyc_code), 0);
        chk("R1 phase", int'(cyc_phase), 0);
        chk("R1 strobes", int'({hold_ack, bus_req, io_cycle, host_irq, host_ack}), 0);
        rst_n = 1;
        tick(); tick();
        chk("R1 after release", int'(cyc_code), 0);
        seq.delete();

        // R3 host cycles of each kind
        host_op(0, 1, 7, "R3 onboard read");
        host_op(0, 0, 8, "R3 onboard write");
        host_op(1, 1, 9, "R3 ctl read");
        rdy_dly = 3;
        host_op(1, 0, 10, "R3 R8 ctl write with ready wait");
        rdy_dly = 0;
        host_op(2, 1, 11, "R3 latch read");
        host_op(3, 0, 8, "R3 latch write");

        // R4 single DMA read, slow grant
        grant_dly = 3; dma_dir_wr = 0; hold_target = 1; dma_seen = 0; hold_req = 1;
        wait_done("R4 single");
        exp_q = '{1, 2, 0}; check_seq("R4 single read sequence");
        chk("R5 single word count", dma_seen, 1);

        // R5 burst of eight writes with ready waits
        grant_dly = 1; rdy_dly = 2; dma_dir_wr = 1; hold_target = 8; dma_seen = 0; gaps = 0;
        hold_req = 1;
        wait_done("R5 burst");
        exp_q = '{1, 3, 0}; check_seq("R5 burst sequence");
        chk("R5 burst word count", dma_seen, 8);
        chk("R5 no idle inside burst", gaps, 0);
        rdy_dly = 0;

        // R6 R9 interrupt chain with slow grant
        dma_en = 1; grant_dly = 4; ctl_irq = 1;
        wait_done("R6 chain");
        exp_q = '{4, 5, 6, 0}; check_seq("R6 R9 chain sequence");

        // R7 interrupt ignored while DMA is disabled
        dma_en = 0; ctl_irq = 1; host_kind = 0; host_rw = 1; host_req = 1;
        wait_done("R7 host");
        repeat (20) tick();
        exp_q = '{7, 0}; check_seq("R7 irq ignored");
        ctl_irq = 0;

        // R2 all three at once
        dma_en = 1; grant_dly = 0; dma_dir_wr = 0; hold_target = 2; dma_seen = 0;
        hold_req = 1; ctl_irq = 1; host_kind = 0; host_rw = 1; host_req = 1;
        wait_done("R2 priority");
        exp_q = '{1, 2, 0, 4, 5, 6, 0, 7, 0}; check_seq("R2 priority order");

        // R3 host request arriving mid DMA burst waits for idle
        rdy_dly = 3; hold_target = 3; dma_seen = 0; hold_req = 1;
        repeat (6) tick();
        host_kind = 1; host_rw = 0; host_req = 1;
        wait_done("R3 mid burst");
        exp_q = '{1, 2, 0, 10, 0}; check_seq("R3 host waits for idle");
        chk("R3 host served count", host_done, 9);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule